// File: doc/BRIEF.md
# Sink Capability and EDID Validator

This block checks what a display sink reports about itself before a link is brought up. It sits behind whatever engine moves bytes over the auxiliary channel, and it takes those bytes one at a time on a valid/ready input. A start pulse opens a session, and a phase select chooses what the session checks. In the capability phase the block reads the sink's receiver-capability bytes. In the EDID phase it reads one or two 128-byte EDID blocks.

From the capability bytes the block extracts the revision, the maximum link rate, the maximum lane count and the enhanced-framing flag. It then raises `done` with a pass or error code. For EDID it keeps a running modulo-256 sum of each block. It decides whether a second block follows from the extension count in the first block. On success it returns the final checksum byte so the caller can answer a sink test request. A transport failure during the capability read can be signalled by the caller, and the block restarts the read a bounded number of times.

Top module: `sink_link_validator`

## Requirements
- R1: A `start` pulse clears `done`, `err_code` and the capability fields to 0 and begins a session. `phase_edid`=0 selects the capability phase and 1 selects the EDID phase. `in_ready` is 1 while a session collects bytes and 0 otherwise. Out of reset, `in_ready`, `done`, `err_code` and `resp_valid` are 0.
- R2: The capability phase accepts exactly 12 bytes. Byte 0 is the revision, byte 1 the link-rate code and byte 2 the lane byte. `done` rises in the cycle after the 12th byte is accepted and stays high until the next `start`.
- R3: The revision must be 0x10 or 0x11, otherwise `err_code`=1. Checks apply in the order revision, rate, lane count, and the first failing check sets the code. `err_code`=0 means pass.
- R4: The link-rate byte must be 0x06 (1.62 Gbps) or 0x0A (2.7 Gbps), otherwise `err_code`=2.
- R5: At revision 0x11, `cap_lanes` is bits [4:0] of the lane byte and `cap_enh` is its bit 7. At any other revision, `cap_lanes` is the whole byte and `cap_enh` is 0.
- R6: The lane count must be 1, 2 or 4, otherwise `err_code`=3.
- R7: Each EDID block is 128 bytes. If the modulo-256 sum of a block is nonzero, the block sets `done` with `err_code`=4 after that block's last byte and accepts no further bytes.
- R8: If byte 126 of the first EDID block is nonzero, a second 128-byte block is read and checked. Otherwise the session ends after the first block. Byte 126 of the second block has no effect.
- R9: When an EDID session passes, `resp_cksum` holds byte 127 of the last block checked. `resp_valid` pulses for one cycle, with `done`, only if `tst_edid_req` was 1 when that byte was accepted. `resp_valid` never pulses on a failure.
- R10: A `cap_abort` during the capability phase drops the bytes taken so far and restarts at byte 0, up to 5 times. The 6th abort ends the session with `done` and `err_code`=5.
- R11: `cap_abort` has no effect during the EDID phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a session (restarts one in progress) |
| phase_edid | input | 1 | Session kind at start: 0 capability, 1 EDID |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Block takes a byte this cycle if valid |
| cap_abort | input | 1 | Transport failure of the current capability read |
| tst_edid_req | input | 1 | Sink's test request asks for the EDID checksum |
| done | output | 1 | Session finished; result outputs valid |
| err_code | output | 3 | 0 pass, 1 revision, 2 rate, 3 lanes, 4 checksum, 5 retries exhausted |
| cap_rev | output | 8 | Revision byte |
| cap_rate | output | 8 | Maximum link-rate code |
| cap_lanes | output | 8 | Maximum lane count |
| cap_enh | output | 1 | Enhanced framing supported |
| resp_valid | output | 1 | Checksum-written response strobe |
| resp_cksum | output | 8 | Checksum byte to report back |

## Verification
The assertions take for granted that `start` is a single-cycle pulse and that the reported fields come only from a finished session. A pass result may carry zeroed capability fields, because an EDID session leaves them cleared. The stimulus raises `start` only between sessions, or deliberately mid-session for the restart case. It pulses `cap_abort` only while no byte is offered, and it keeps `tst_edid_req` steady through each EDID session. Random capability bytes are drawn with a bias toward legal codes so that every error code and both revisions occur. EDID blocks are built with a computed checksum byte, with a corrupt variant in either block.

// File: rtl/slv_pkg.sv
package slv_pkg;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_REV    = 3'd1,
        ERR_RATE   = 3'd2,
        ERR_LANES  = 3'd3,
        ERR_CKSUM  = 3'd4,
        ERR_NORESP = 3'd5
    } slv_err_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAP  = 2'd1,
        ST_EDID = 2'd2
    } slv_state_e;

    localparam logic [7:0] REV_V10  = 8'h10;
    localparam logic [7:0] REV_V11  = 8'h11;
    localparam logic [7:0] RATE_162 = 8'h06;
    localparam logic [7:0] RATE_270 = 8'h0A;

    typedef struct packed {
        logic [7:0] rev;
        logic [7:0] rate;
        logic [7:0] lanes;
        logic       enh;
    } slv_caps_t;

    function automatic logic rev_legal(logic [7:0] r);
        return (r == REV_V10) || (r == REV_V11);
    endfunction

    function automatic logic rate_legal(logic [7:0] r);
        return (r == RATE_162) || (r == RATE_270);
    endfunction

    function automatic logic lanes_legal(logic [7:0] n);
        return (n == 8'd1) || (n == 8'd2) || (n == 8'd4);
    endfunction

endpackage

// File: rtl/slv_cap_decode.sv
module slv_cap_decode
    import slv_pkg::*;
(
    input  logic [7:0] rev_byte,
    input  logic [7:0] rate_byte,
    input  logic [7:0] lane_byte,
    output slv_caps_t  caps,
    output slv_err_e   verdict
);
    always_comb begin
        caps.rev  = rev_byte;
        caps.rate = rate_byte;
        if (rev_byte == REV_V11) begin
            caps.lanes = {3'b000, lane_byte[4:0]};
            caps.enh   = lane_byte[7];
        end else begin
            caps.lanes = lane_byte;
            caps.enh   = 1'b0;
        end

        if (!rev_legal(rev_byte))
            verdict = ERR_REV;
        else if (!rate_legal(rate_byte))
            verdict = ERR_RATE;
        else if (!lanes_legal(caps.lanes))
            verdict = ERR_LANES;
        else
            verdict = ERR_NONE;
    end
endmodule

// File: rtl/slv_sum_acc.sv
module slv_sum_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum_nxt
);
    logic [W-1:0] sum_q;

    assign sum_nxt = sum_q + din;

    always_ff @(posedge clk) begin
        if (rst || clr)
            sum_q <= '0;
        else if (add)
            sum_q <= sum_nxt;
    end
endmodule

// File: rtl/sink_link_validator.sv
module sink_link_validator
    import slv_pkg::*;
#(
    parameter int CAP_BYTES = 12,
    parameter int EDID_LEN  = 128,
    parameter int MAX_RETRY = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       phase_edid,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       cap_abort,
    input  logic       tst_edid_req,
    output logic       done,
    output logic [2:0] err_code,
    output logic [7:0] cap_rev,
    output logic [7:0] cap_rate,
    output logic [7:0] cap_lanes,
    output logic       cap_enh,
    output logic       resp_valid,
    output logic [7:0] resp_cksum
);
    localparam int SPAN  = (EDID_LEN > CAP_BYTES) ? EDID_LEN : CAP_BYTES;
    localparam int IDX_W = $clog2(SPAN);
    localparam int RTY_W = $clog2(MAX_RETRY + 1);
    localparam logic [IDX_W-1:0] CAP_LAST  = IDX_W'(CAP_BYTES - 1);
    localparam logic [IDX_W-1:0] EDID_LAST = IDX_W'(EDID_LEN - 1);
    localparam logic [IDX_W-1:0] EXT_POS   = IDX_W'(EDID_LEN - 2);
    localparam int HDR_BYTES = 3;

    slv_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [RTY_W-1:0] retry_q;
    logic             second_q;
    logic             ext_q;
    logic             done_q;
    slv_err_e         err_q;
    slv_caps_t        caps_q;
    logic             resp_v_q;
    logic [7:0]       resp_ck_q;
    logic [7:0]       hdr_q [HDR_BYTES];

    slv_caps_t dec_caps;
    slv_err_e  dec_err;
    logic [7:0] sum_nxt;
    logic take, edid_take, acc_clr;

    assign in_ready  = (state_q != ST_IDLE);
    assign take      = in_valid && in_ready;
    assign edid_take = take && (state_q == ST_EDID);
    assign acc_clr   = start || (edid_take && idx_q == EDID_LAST);

    slv_cap_decode u_dec (
        .rev_byte  (hdr_q[0]),
        .rate_byte (hdr_q[1]),
        .lane_byte (hdr_q[2]),
        .caps      (dec_caps),
        .verdict   (dec_err)
    );

    slv_sum_acc #(.W(8)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (acc_clr),
        .add     (edid_take),
        .din     (in_data),
        .sum_nxt (sum_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            retry_q   <= '0;
            second_q  <= 1'b0;
            ext_q     <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= ERR_NONE;
            caps_q    <= '0;
            resp_v_q  <= 1'b0;
            resp_ck_q <= '0;
            for (int i = 0; i < HDR_BYTES; i++) hdr_q[i] <= '0;
        end else begin
            resp_v_q <= 1'b0;
            if (start) begin
                state_q  <= phase_edid ? ST_EDID : ST_CAP;
                idx_q    <= '0;
                retry_q  <= '0;
                second_q <= 1'b0;
                ext_q    <= 1'b0;
                done_q   <= 1'b0;
                err_q    <= ERR_NONE;
                caps_q   <= '0;
            end else begin
                case (state_q)
                    ST_CAP: begin
                        if (cap_abort) begin
                            if (retry_q == RTY_W'(MAX_RETRY)) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                                err_q   <= ERR_NORESP;
                            end else begin
                                retry_q <= retry_q + 1'b1;
                                idx_q   <= '0;
                            end
                        end else if (take) begin
                            for (int i = 0; i < HDR_BYTES; i++)
                                if (idx_q == IDX_W'(i)) hdr_q[i] <= in_data;
                            if (idx_q == CAP_LAST) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                                err_q   <= dec_err;
                                caps_q  <= dec_caps;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                    end
                    ST_EDID: begin
                        if (take) begin
                            if (idx_q == EXT_POS && !second_q)
                                ext_q <= (in_data != 8'h00);
                            if (idx_q == EDID_LAST) begin
                                if (sum_nxt != 8'h00) begin
                                    state_q <= ST_IDLE;
                                    done_q  <= 1'b1;
                                    err_q   <= ERR_CKSUM;
                                end else if (!second_q && ext_q) begin
                                    second_q <= 1'b1;
                                    idx_q    <= '0;
                                end else begin
                                    state_q   <= ST_IDLE;
                                    done_q    <= 1'b1;
                                    err_q     <= ERR_NONE;
                                    resp_ck_q <= in_data;
                                    resp_v_q  <= tst_edid_req;
                                end
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign done       = done_q;
    assign err_code   = err_q;
    assign cap_rev    = caps_q.rev;
    assign cap_rate   = caps_q.rate;
    assign cap_lanes  = caps_q.lanes;
    assign cap_enh    = caps_q.enh;
    assign resp_valid = resp_v_q;
    assign resp_cksum = resp_ck_q;
endmodule

// File: rtl/slv_checker.sv
module slv_checker (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       in_ready,
    input logic       done,
    input logic [2:0] err_code,
    input logic [7:0] cap_rev,
    input logic [7:0] cap_rate,
    input logic [7:0] cap_lanes,
    input logic       cap_enh,
    input logic       resp_valid
);
    AST_IDLE_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready); // R1

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R2

    AST_PASS_REV_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 3'd0 && cap_rev != 8'h00) |-> (cap_rev == 8'h10 || cap_rev == 8'h11)); // R3

    AST_PASS_RATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 3'd0 && cap_rate != 8'h00) |-> (cap_rate == 8'h06 || cap_rate == 8'h0A)); // R4

    AST_ENH_NEEDS_REV11: assert property (@(posedge clk) disable iff (rst)
        cap_enh |-> (cap_rev == 8'h11)); // R5

    AST_PASS_LANES_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 3'd0 && cap_lanes != 8'h00) |-> $onehot(cap_lanes) && cap_lanes < 8'd8); // R6

    AST_RESP_ON_PASS: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (done && err_code == 3'd0)); // R9

    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid); // R9
endmodule

bind sink_link_validator slv_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .in_ready   (in_ready),
    .done       (done),
    .err_code   (err_code),
    .cap_rev    (cap_rev),
    .cap_rate   (cap_rate),
    .cap_lanes  (cap_lanes),
    .cap_enh    (cap_enh),
    .resp_valid (resp_valid)
);

// File: tb/sink_link_validator_tb.sv
module sink_link_validator_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       phase_edid = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       cap_abort = 1'b0;
    logic       tst_edid_req = 1'b0;
    logic       done;
    logic [2:0] err_code;
    logic [7:0] cap_rev, cap_rate, cap_lanes;
    logic       cap_enh;
    logic       resp_valid;
    logic [7:0] resp_cksum;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [7:0] edb [0:1][0:127];

    always #5 clk = ~clk;

    sink_link_validator u_dut (
        .clk(clk), .rst(rst), .start(start), .phase_edid(phase_edid),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .cap_abort(cap_abort), .tst_edid_req(tst_edid_req), .done(done),
        .err_code(err_code), .cap_rev(cap_rev), .cap_rate(cap_rate),
        .cap_lanes(cap_lanes), .cap_enh(cap_enh), .resp_valid(resp_valid),
        .resp_cksum(resp_cksum)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void exp_caps(input logic [7:0] b0, b1, b2,
                                     output logic [2:0] e, output logic [7:0] ln, output logic en);
        ln = (b0 == 8'h11) ? (b2 & 8'h1F) : b2;
        en = (b0 == 8'h11) ? b2[7] : 1'b0;
        if (b0 != 8'h10 && b0 != 8'h11) e = 3'd1;
        else if (b1 != 8'h06 && b1 != 8'h0A) e = 3'd2;
        else if (ln != 8'd1 && ln != 8'd2 && ln != 8'd4) e = 3'd3;
        else e = 3'd0;
    endfunction

    task automatic do_start(input bit ph);
        start = 1'b1; phase_edid = ph;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_abort();
        cap_abort = 1'b1;
        @(negedge clk);
        cap_abort = 1'b0;
    endtask

    task automatic run_cap(input logic [7:0] b0, b1, b2, input bit gaps);
        logic [2:0] e; logic [7:0] ln; logic en;
        exp_caps(b0, b1, b2, e, ln, en);
        do_start(1'b0);
        check("R1 ready after start", in_ready, 1);
        for (int i = 0; i < 12; i++) begin
            if (i == 11) check("R2 not done before 12th byte", done, 0);
            if (gaps && ($urandom % 3 == 0)) @(negedge clk);
            send(i == 0 ? b0 : i == 1 ? b1 : i == 2 ? b2 : 8'($urandom));
        end
        check("R2 done after 12 bytes", done, 1);
        check("R2 ready drops", in_ready, 0);
        check("R3 R4 R6 error code", err_code, e);
        check("R2 revision", cap_rev, b0);
        check("R2 rate", cap_rate, b1);
        check("R5 lanes", cap_lanes, ln);
        check("R5 enhanced flag", cap_enh, en);
    endtask

    task automatic run_edid(input bit two, input int bad, input bit treq, input bit ab);
        int s;
        int lastb;
        for (int b = 0; b < 2; b++) begin
            s = 0;
            for (int i = 0; i < 127; i++) begin
                edb[b][i] = 8'($urandom);
                if (b == 0 && i == 126) edb[0][126] = two ? 8'(1 + $urandom % 3) : 8'h00;
                s += edb[b][i];
            end
            edb[b][127] = 8'(256 - (s % 256));
            if (bad == b + 1) edb[b][127] = edb[b][127] + 8'(1 + $urandom % 200);
        end
        tst_edid_req = treq;
        do_start(1'b1);
        for (int i = 0; i < 128; i++) begin
            send(edb[0][i]);
            if (ab && i == 40) pulse_abort();
        end
        if (bad == 1) begin
            check("R7 done on bad first block", done, 1);
            check("R7 checksum error", err_code, 4);
            check("R7 stops taking bytes", in_ready, 0);
            check("R9 no response on failure", resp_valid, 0);
            return;
        end
        lastb = 0;
        if (two) begin
            check("R8 not done after first block", done, 0);
            check("R8 still ready for second block", in_ready, 1);
            for (int i = 0; i < 128; i++) send(edb[1][i]);
            lastb = 1;
            if (bad == 2) begin
                check("R7 done on bad second block", done, 1);
                check("R7 checksum error second", err_code, 4);
                check("R9 no response on failure", resp_valid, 0);
                return;
            end
        end
        check(ab ? "R11 pass despite abort" : "R7 EDID done", done, 1);
        check("R7 pass code", err_code, 0);
        check("R8 session ended", in_ready, 0);
        check("R9 checksum byte", resp_cksum, edb[lastb][127]);
        check("R9 response strobe", resp_valid, treq);
        @(negedge clk);
        check("R9 strobe one cycle", resp_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset ready", in_ready, 0);
        check("R1 reset done", done, 0);
        check("R1 reset err", err_code, 0);
        check("R1 reset resp", resp_valid, 0);

        // directed capability corners
        run_cap(8'h11, 8'h0A, 8'h84, 0);
        run_cap(8'h10, 8'h06, 8'h84, 0);
        run_cap(8'h10, 8'h06, 8'h02, 0);
        run_cap(8'h12, 8'h33, 8'h03, 0);
        run_cap(8'h11, 8'h07, 8'h03, 0);
        run_cap(8'h11, 8'h06, 8'h83, 0);
        run_cap(8'h11, 8'h06, 8'hE1, 1);

        // start clears a failed result
        do_start(1'b0);
        check("R1 start clears done", done, 0);
        check("R1 start clears err", err_code, 0);
        check("R1 start clears lanes", cap_lanes, 0);

        // random capability bytes
        for (int n = 0; n < 40; n++) begin
            logic [7:0] b0, b1, b2;
            case ($urandom % 4) 0: b0 = 8'h10; 1, 3: b0 = 8'h11; default: b0 = 8'($urandom); endcase
            case ($urandom % 4) 0: b1 = 8'h06; 1, 3: b1 = 8'h0A; default: b1 = 8'($urandom); endcase
            case ($urandom % 5)
                0: b2 = 8'd1; 1: b2 = 8'd2; 2: b2 = 8'd4;
                3: b2 = 8'h80 | 8'(1 << ($urandom % 3));
                default: b2 = 8'($urandom);
            endcase
            run_cap(b0, b1, b2, 1);
        end

        // retries: five aborts then success
        do_start(1'b0);
        for (int k = 0; k < 5; k++) begin
            send(8'h11); send(8'h0A); send(8'h02);
            pulse_abort();
        end
        check("R10 ready after five aborts", in_ready, 1);
        check("R10 not done after five aborts", done, 0);
        send(8'h10); send(8'h0A); send(8'h01);
        for (int i = 3; i < 12; i++) send(8'h00);
        check("R10 restart from byte 0", done, 1);
        check("R10 restart result", err_code, 0);
        check("R10 restart lanes", cap_lanes, 1);

        // retries: sixth abort fails
        do_start(1'b0);
        for (int k = 0; k < 6; k++) begin
            send(8'h11);
            pulse_abort();
        end
        check("R10 done after sixth abort", done, 1);
        check("R10 exhausted code", err_code, 5);
        check("R10 ready drops", in_ready, 0);

        // EDID
        run_edid(0, 0, 1, 0);
        run_edid(0, 0, 0, 0);
        run_edid(1, 0, 1, 0);
        run_edid(1, 0, 0, 0);
        run_edid(0, 1, 1, 0);
        run_edid(1, 1, 1, 0);
        run_edid(1, 2, 1, 0);
        run_edid(0, 0, 1, 1);
        run_edid(1, 0, 1, 1);
        for (int n = 0; n < 6; n++)
            run_edid(1'($urandom), int'($urandom % 3), 1'($urandom), 1'($urandom));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule